// File: doc/BRIEF.md
# Extension Interface Identifier Translator and Command Router

This unit sits between the instruction pipeline and a set of pluggable extension devices. Software names an extension interface by a globally unique identifier. The unit looks that identifier up in a small table and returns a short local unit number. The identifier has an upper interface part of 20 bits, or 52 bits when XLEN is 64, and a 3-bit sub-field below it. The lookup keeps no record of the request. It does not wake any device and allocates nothing. When the identifier is unknown, or is not permitted at the caller's privilege level, the lookup returns the reserved number zero.

The second job of the unit is to route the eight generic commands, numbered 0 to 7, to the device that owns a unit number. Each command carries two operands, and the low 12 bits of the first operand select the unit. For a non-zero unit, the unit forwards the command to the device port over a valid/ready handshake. It then returns the device's answer as a single-cycle result pulse. For unit zero, the command never reaches a device. Instead it raises a trap, or, in a build-time variant, returns a fixed all-zeros or all-ones value.

Top module: `uuid_lun_router`

## Requirements
- R1: After a synchronous reset, `tr_ack`, `res_valid` and `dev_valid` are low, `cmd_ready` is high, `tr_lun` is zero, and every table slot is empty, so any translation returns zero.
- R2: A translation request is answered one cycle later by a one-cycle `tr_ack`. On a hit, `tr_lun` equals {slot unit number (12 bits), the key's low 3 bits}.
- R3: A key whose upper 20 bits match no valid slot returns `tr_lun` = 0 in all 15 bits. A hit on a slot that holds unit number 0 also returns 0 in all 15 bits.
- R4: Privilege codes are 2 bits: 0 user, 1 supervisor, 3 machine. A slot grants access when the request privilege is numerically greater than or equal to the slot's minimum. A match on a slot that does not grant access counts as no match.
- R5: When several permitted slots match the key, the slot with the lowest index supplies the result.
- R6: Several slots may map different identifiers to the same unit number. Each of those identifiers then translates to that unit.
- R7: A configuration write replaces all fields of the addressed slot. Writing the slot with its valid bit clear removes its mapping from later lookups.
- R8: A command whose first operand has a non-zero low 12 bits is presented on the device port. The port carries `dev_op` equal to the command index, `dev_lun` equal to those 12 bits, `dev_a` equal to the whole first operand and `dev_b` equal to the second operand. The request stays stable until `dev_ready` is high.
- R9: The device answer from `dev_rdata`, taken when `dev_rvalid` is high, appears on `res_data` with a one-cycle `res_valid` pulse and `res_trap` low.
- R10: In the default trap build, a command with unit number 0 never raises `dev_valid`. Its result pulse comes in the cycle after acceptance, with `res_trap` high and `res_data` zero.
- R11: In the fallback builds (FB_MODE = FB_ZERO or FB_ONES), a unit-0 command returns `res_trap` low with `res_data` all zeros or all ones respectively.
- R12: `cmd_ready` is low from the cycle after a non-zero-unit command is accepted until its result has been returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one table slot |
| cfg_slot | input | IDX_W | Slot index being written |
| cfg_valid | input | 1 | Valid bit stored in the slot |
| cfg_iface | input | IFACE_W | Upper interface identifier stored in the slot |
| cfg_lun | input | LUN_W | Unit number stored in the slot |
| cfg_priv | input | 2 | Minimum privilege stored in the slot |
| tr_req | input | 1 | Translation request |
| tr_key | input | IFACE_W+3 | Full identifier to translate |
| tr_priv | input | 2 | Privilege of the requester |
| tr_ack | output | 1 | Translation answer strobe |
| tr_lun | output | LUN_W+3 | Unit number and sub-field, or zero |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command index 0 to 7 |
| cmd_a | input | XLEN | First operand; low 12 bits select the unit |
| cmd_b | input | XLEN | Second operand |
| res_valid | output | 1 | Result strobe |
| res_trap | output | 1 | Command trapped |
| res_data | output | XLEN | Result value |
| dev_valid | output | 1 | Request to a device |
| dev_ready | input | 1 | Device accepts the request |
| dev_op | output | 3 | Command index for the device |
| dev_lun | output | LUN_W | Selected unit |
| dev_a | output | XLEN | First operand to the device |
| dev_b | output | XLEN | Second operand to the device |
| dev_rvalid | input | 1 | Device answer strobe |
| dev_rdata | input | XLEN | Device answer |

## Verification
The assertions assume that devices follow the handshake. They assume that `dev_rvalid` comes only after a request has been accepted, once per request, and that a caller offers a command only for a single cycle while `cmd_ready` is high. The stimulus pulses `cmd_valid` for one cycle per command and uses a device model that answers exactly one cycle after each accepted request. Two further instances in the fallback builds receive the same stimulus in lockstep, so the device model's timing fits all three instances.

// File: rtl/xlu_pkg.sv
package xlu_pkg;
  typedef enum logic [1:0] {
    FB_TRAP = 2'd0,
    FB_ZERO = 2'd1,
    FB_ONES = 2'd2
  } fb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } disp_state_e;

  localparam int SUB_W  = 3;
  localparam int PRIV_W = 2;
  localparam int OP_W   = 3;
endpackage

// File: rtl/xlu_match.sv
module xlu_match #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/xlu_table.sv
module xlu_table #(
  parameter int NENT    = 8,
  parameter int IFACE_W = 20,
  parameter int LUN_W   = 12,
  localparam int IDX_W  = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int KEY_W  = IFACE_W + xlu_pkg::SUB_W,
  localparam int OUT_W  = LUN_W + xlu_pkg::SUB_W,
  localparam int PRIV_W = xlu_pkg::PRIV_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_slot,
  input  logic               cfg_valid,
  input  logic [IFACE_W-1:0] cfg_iface,
  input  logic [LUN_W-1:0]   cfg_lun,
  input  logic [PRIV_W-1:0]  cfg_priv,
  input  logic               tr_req,
  input  logic [KEY_W-1:0]   tr_key,
  input  logic [PRIV_W-1:0]  tr_priv,
  output logic               tr_ack,
  output logic [OUT_W-1:0]   tr_lun
);
  localparam int SUB_W = xlu_pkg::SUB_W;

  logic [NENT-1:0]    slot_ok;
  logic [IFACE_W-1:0] slot_iface [NENT];
  logic [LUN_W-1:0]   slot_lun   [NENT];
  logic [PRIV_W-1:0]  slot_priv  [NENT];
  logic [NENT-1:0]    hit;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [LUN_W-1:0]   hit_lun;

  always_ff @(posedge clk) begin
    if (rst) slot_ok <= '0;
    else if (cfg_we) slot_ok[cfg_slot] <= cfg_valid;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      slot_iface[cfg_slot] <= cfg_iface;
      slot_lun[cfg_slot]   <= cfg_lun;
      slot_priv[cfg_slot]  <= cfg_priv;
    end
  end

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    assign hit[g] = slot_ok[g]
                 && (slot_iface[g] == tr_key[KEY_W-1:SUB_W])
                 && (tr_priv >= slot_priv[g]);
  end

  xlu_match #(.N(NENT)) u_match (
    .req (hit),
    .any (hit_any),
    .idx (hit_idx)
  );

  assign hit_lun = slot_lun[hit_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_ack <= 1'b0;
      tr_lun <= '0;
    end else begin
      tr_ack <= tr_req;
      if (tr_req) begin
        if (hit_any && (hit_lun != '0)) tr_lun <= {hit_lun, tr_key[SUB_W-1:0]};
        else tr_lun <= '0;
      end
    end
  end

  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    tr_req |=> tr_ack);

  assert_zero_unit_clears_sub_R3: assert property (@(posedge clk) disable iff (rst)
    (tr_ack && (tr_lun[OUT_W-1:SUB_W] == '0)) |-> (tr_lun[SUB_W-1:0] == '0));
endmodule

// File: rtl/xlu_dispatch.sv
module xlu_dispatch #(
  parameter int XLEN  = 32,
  parameter int LUN_W = 12,
  parameter xlu_pkg::fb_mode_e FB_MODE = xlu_pkg::FB_TRAP,
  localparam int OP_W = xlu_pkg::OP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [OP_W-1:0] cmd_op,
  input  logic [XLEN-1:0] cmd_a,
  input  logic [XLEN-1:0] cmd_b,
  output logic            res_valid,
  output logic            res_trap,
  output logic [XLEN-1:0] res_data,
  output logic            dev_valid,
  input  logic            dev_ready,
  output logic [OP_W-1:0] dev_op,
  output logic [LUN_W-1:0] dev_lun,
  output logic [XLEN-1:0] dev_a,
  output logic [XLEN-1:0] dev_b,
  input  logic            dev_rvalid,
  input  logic [XLEN-1:0] dev_rdata
);
  import xlu_pkg::*;

  disp_state_e      state;
  logic             accept;
  logic [LUN_W-1:0] cmd_lun;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_lun   = cmd_a[LUN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      res_valid <= 1'b0;
      res_trap  <= 1'b0;
      res_data  <= '0;
      dev_valid <= 1'b0;
      dev_op    <= '0;
      dev_lun   <= '0;
      dev_a     <= '0;
      dev_b     <= '0;
    end else begin
      res_valid <= 1'b0;
      res_trap  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (cmd_lun == '0) begin
              res_valid <= 1'b1;
              res_trap  <= (FB_MODE == FB_TRAP);
              res_data  <= (FB_MODE == FB_ONES) ? {XLEN{1'b1}} : {XLEN{1'b0}};
            end else begin
              dev_valid <= 1'b1;
              dev_op    <= cmd_op;
              dev_lun   <= cmd_lun;
              dev_a     <= cmd_a;
              dev_b     <= cmd_b;
              state     <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (dev_ready) begin
            dev_valid <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dev_rvalid) begin
            res_valid <= 1'b1;
            res_data  <= dev_rdata;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
    (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_op) && $stable(dev_lun)
                                   && $stable(dev_a) && $stable(dev_b)));

  assert_zero_unit_no_device_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_valid) |-> ($past(cmd_valid) && ($past(cmd_a[LUN_W-1:0]) != '0)));

  assert_trap_payload_R10: assert property (@(posedge clk) disable iff (rst)
    res_trap |-> (res_valid && (res_data == '0)));
endmodule

// File: rtl/uuid_lun_router.sv
module uuid_lun_router #(
  parameter int XLEN    = 32,
  parameter int NENT    = 8,
  parameter int LUN_W   = 12,
  parameter int IFACE_W = (XLEN == 64) ? 52 : 20,
  parameter xlu_pkg::fb_mode_e FB_MODE = xlu_pkg::FB_TRAP,
  localparam int IDX_W  = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int KEY_W  = IFACE_W + xlu_pkg::SUB_W,
  localparam int OUT_W  = LUN_W + xlu_pkg::SUB_W,
  localparam int PRIV_W = xlu_pkg::PRIV_W,
  localparam int OP_W   = xlu_pkg::OP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_slot,
  input  logic               cfg_valid,
  input  logic [IFACE_W-1:0] cfg_iface,
  input  logic [LUN_W-1:0]   cfg_lun,
  input  logic [PRIV_W-1:0]  cfg_priv,
  input  logic               tr_req,
  input  logic [KEY_W-1:0]   tr_key,
  input  logic [PRIV_W-1:0]  tr_priv,
  output logic               tr_ack,
  output logic [OUT_W-1:0]   tr_lun,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [OP_W-1:0]    cmd_op,
  input  logic [XLEN-1:0]    cmd_a,
  input  logic [XLEN-1:0]    cmd_b,
  output logic               res_valid,
  output logic               res_trap,
  output logic [XLEN-1:0]    res_data,
  output logic               dev_valid,
  input  logic               dev_ready,
  output logic [OP_W-1:0]    dev_op,
  output logic [LUN_W-1:0]   dev_lun,
  output logic [XLEN-1:0]    dev_a,
  output logic [XLEN-1:0]    dev_b,
  input  logic               dev_rvalid,
  input  logic [XLEN-1:0]    dev_rdata
);
  xlu_table #(
    .NENT(NENT), .IFACE_W(IFACE_W), .LUN_W(LUN_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_valid(cfg_valid),
    .cfg_iface(cfg_iface), .cfg_lun(cfg_lun), .cfg_priv(cfg_priv),
    .tr_req(tr_req), .tr_key(tr_key), .tr_priv(tr_priv),
    .tr_ack(tr_ack), .tr_lun(tr_lun)
  );

  xlu_dispatch #(
    .XLEN(XLEN), .LUN_W(LUN_W), .FB_MODE(FB_MODE)
  ) u_disp (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b),
    .res_valid(res_valid), .res_trap(res_trap), .res_data(res_data),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_op(dev_op),
    .dev_lun(dev_lun), .dev_a(dev_a), .dev_b(dev_b),
    .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata)
  );
endmodule

// File: tb/uuid_lun_router_bench.sv
module uuid_lun_router_bench;
  import xlu_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        cfg_we, cfg_valid;
  logic [2:0]  cfg_slot;
  logic [19:0] cfg_iface;
  logic [11:0] cfg_lun;
  logic [1:0]  cfg_priv;
  logic        tr_req;
  logic [22:0] tr_key;
  logic [1:0]  tr_priv;
  logic        tr_ack;
  logic [14:0] tr_lun;
  logic        cmd_valid, cmd_ready;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_a, cmd_b;
  logic        res_valid, res_trap;
  logic [31:0] res_data;
  logic        dev_valid, dev_ready;
  logic [2:0]  dev_op;
  logic [11:0] dev_lun;
  logic [31:0] dev_a, dev_b;
  logic        dev_rvalid;
  logic [31:0] dev_rdata;

  // lockstep fallback-build instances
  logic        tr_ack_o, tr_ack_z, cmd_ready_o, cmd_ready_z;
  logic [14:0] tr_lun_o, tr_lun_z;
  logic        res_valid_o, res_trap_o, res_valid_z, res_trap_z;
  logic [31:0] res_data_o, res_data_z;
  logic        dev_valid_o, dev_valid_z;
  logic [2:0]  dev_op_o, dev_op_z;
  logic [11:0] dev_lun_o, dev_lun_z;
  logic [31:0] dev_a_o, dev_b_o, dev_a_z, dev_b_z;

  uuid_lun_router u_uuid_lun_router (
    .clk, .rst, .cfg_we, .cfg_slot, .cfg_valid, .cfg_iface, .cfg_lun, .cfg_priv,
    .tr_req, .tr_key, .tr_priv, .tr_ack, .tr_lun,
    .cmd_valid, .cmd_ready, .cmd_op, .cmd_a, .cmd_b,
    .res_valid, .res_trap, .res_data,
    .dev_valid, .dev_ready, .dev_op, .dev_lun, .dev_a, .dev_b,
    .dev_rvalid, .dev_rdata
  );

  uuid_lun_router #(.FB_MODE(FB_ONES)) u_uuid_lun_router_ones (
    .clk, .rst, .cfg_we, .cfg_slot, .cfg_valid, .cfg_iface, .cfg_lun, .cfg_priv,
    .tr_req, .tr_key, .tr_priv, .tr_ack(tr_ack_o), .tr_lun(tr_lun_o),
    .cmd_valid, .cmd_ready(cmd_ready_o), .cmd_op, .cmd_a, .cmd_b,
    .res_valid(res_valid_o), .res_trap(res_trap_o), .res_data(res_data_o),
    .dev_valid(dev_valid_o), .dev_ready, .dev_op(dev_op_o), .dev_lun(dev_lun_o),
    .dev_a(dev_a_o), .dev_b(dev_b_o), .dev_rvalid, .dev_rdata
  );

  uuid_lun_router #(.FB_MODE(FB_ZERO)) u_uuid_lun_router_zero (
    .clk, .rst, .cfg_we, .cfg_slot, .cfg_valid, .cfg_iface, .cfg_lun, .cfg_priv,
    .tr_req, .tr_key, .tr_priv, .tr_ack(tr_ack_z), .tr_lun(tr_lun_z),
    .cmd_valid, .cmd_ready(cmd_ready_z), .cmd_op, .cmd_a, .cmd_b,
    .res_valid(res_valid_z), .res_trap(res_trap_z), .res_data(res_data_z),
    .dev_valid(dev_valid_z), .dev_ready, .dev_op(dev_op_z), .dev_lun(dev_lun_z),
    .dev_a(dev_a_z), .dev_b(dev_b_z), .dev_rvalid, .dev_rdata
  );

  // device model: answers one cycle after each accepted request
  function automatic logic [31:0] dev_fn(logic [2:0] op, logic [11:0] lun,
                                         logic [31:0] a, logic [31:0] b);
    return a ^ b ^ {17'd0, lun, op};
  endfunction

  logic [2:0]  seen_op;
  logic [11:0] seen_lun;
  logic [31:0] seen_a, seen_b;
  always_ff @(posedge clk) begin
    if (rst) begin
      dev_rvalid <= 1'b0;
      dev_rdata  <= '0;
    end else begin
      dev_rvalid <= dev_valid && dev_ready;
      if (dev_valid && dev_ready) begin
        dev_rdata <= dev_fn(dev_op, dev_lun, dev_a, dev_b);
        seen_op   <= dev_op;
        seen_lun  <= dev_lun;
        seen_a    <= dev_a;
        seen_b    <= dev_b;
      end
    end
  end

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_slot(int s, bit v, logic [19:0] id, logic [11:0] l, logic [1:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 3'(s); cfg_valid = v;
    cfg_iface = id; cfg_lun = l; cfg_priv = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic translate(logic [22:0] key, logic [1:0] p, output logic [14:0] got,
                           output bit acked);
    @(negedge clk);
    tr_req = 1'b1; tr_key = key; tr_priv = p;
    @(negedge clk);
    tr_req = 1'b0;
    got = tr_lun;
    acked = tr_ack;
  endtask

  // issue one command; returns result fields from the first res_valid pulse
  task automatic issue(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                       output logic [31:0] d, output bit trap, output bit got);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    got = 1'b0; d = '0; trap = 1'b0;
    for (int i = 0; i < 40 && !got; i++) begin
      if (res_valid) begin
        got = 1'b1; d = res_data; trap = res_trap;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  typedef struct packed {
    logic [22:0] key;
    logic [1:0]  priv;
    logic [14:0] exp;
  } tvec_t;

  localparam int NV = 10;
  localparam tvec_t VEC [NV] = '{
    '{ {20'hA1B2C, 3'd5}, 2'd0, {12'h011, 3'd5} }, // R2 R5: slot0 over slot2
    '{ {20'h00055, 3'd0}, 2'd0, 15'd0 },           // R4: user denied on both
    '{ {20'h00055, 3'd7}, 2'd1, {12'h044, 3'd7} }, // R4 R5: slot1 denied, slot3 wins
    '{ {20'h00055, 3'd2}, 2'd3, {12'h022, 3'd2} }, // R5: machine, slot1 lowest
    '{ {20'h7777F, 3'd1}, 2'd0, {12'h011, 3'd1} }, // R6: second id for unit 0x011
    '{ {20'h12345, 3'd3}, 2'd3, 15'd0 },           // R3: slot holds unit 0
    '{ {20'h0BEEF, 3'd4}, 2'd3, 15'd0 },           // R3: slot not valid
    '{ {20'h00099, 3'd6}, 2'd1, 15'd0 },           // R4: below minimum
    '{ {20'h00099, 3'd6}, 2'd2, {12'h077, 3'd6} }, // R4: equal to minimum
    '{ {20'hFFFFF, 3'd0}, 2'd3, 15'd0 }            // R3: unknown id
  };

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [14:0] got_lun;
    bit          acked, got, trap;
    logic [31:0] d;

    rst = 1'b1;
    cfg_we = 1'b0; cfg_slot = '0; cfg_valid = 1'b0; cfg_iface = '0; cfg_lun = '0; cfg_priv = '0;
    tr_req = 1'b0; tr_key = '0; tr_priv = '0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_a = '0; cmd_b = '0;
    dev_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(tr_ack == 1'b0, "R1 tr_ack", 64'(tr_ack), 0);
    check(res_valid == 1'b0, "R1 res_valid", 64'(res_valid), 0);
    check(dev_valid == 1'b0, "R1 dev_valid", 64'(dev_valid), 0);
    check(cmd_ready == 1'b1, "R1 cmd_ready", 64'(cmd_ready), 1);
    check(tr_lun == '0, "R1 tr_lun", 64'(tr_lun), 0);
    translate({20'h00099, 3'd6}, 2'd3, got_lun, acked);
    check(got_lun == '0, "R1 empty table lookup", 64'(got_lun), 0);

    write_slot(0, 1'b1, 20'hA1B2C, 12'h011, 2'd0);
    write_slot(1, 1'b1, 20'h00055, 12'h022, 2'd3);
    write_slot(2, 1'b1, 20'hA1B2C, 12'h033, 2'd0);
    write_slot(3, 1'b1, 20'h00055, 12'h044, 2'd1);
    write_slot(4, 1'b1, 20'h7777F, 12'h011, 2'd0);
    write_slot(5, 1'b1, 20'h12345, 12'h000, 2'd0);
    write_slot(6, 1'b0, 20'h0BEEF, 12'h066, 2'd0);
    write_slot(7, 1'b1, 20'h00099, 12'h077, 2'd2);

    for (int v = 0; v < NV; v++) begin
      translate(VEC[v].key, VEC[v].priv, got_lun, acked);
      check(acked == 1'b1, $sformatf("R2 ack on vector %0d", v), 64'(acked), 1);
      check(got_lun == VEC[v].exp, $sformatf("R2-table vector %0d", v),
            64'(got_lun), 64'(VEC[v].exp));
    end
    @(negedge clk);
    check(tr_ack == 1'b0, "R2 ack is one cycle", 64'(tr_ack), 0);

    // R7: clear slot 0, lookup falls to slot 2
    write_slot(0, 1'b0, 20'hA1B2C, 12'h011, 2'd0);
    translate({20'hA1B2C, 3'd3}, 2'd0, got_lun, acked);
    check(got_lun == {12'h033, 3'd3}, "R7 cleared slot", 64'(got_lun), {12'h033, 3'd3});
    // R7: overwrite slot 7 with a new identifier; old one now misses
    write_slot(7, 1'b1, 20'h00ABC, 12'h0F0, 2'd0);
    translate({20'h00099, 3'd6}, 2'd3, got_lun, acked);
    check(got_lun == '0, "R7 old id removed", 64'(got_lun), 0);
    translate({20'h00ABC, 3'd2}, 2'd0, got_lun, acked);
    check(got_lun == {12'h0F0, 3'd2}, "R7 new id", 64'(got_lun), {12'h0F0, 3'd2});

    // R8 R9 R12: command to unit 0x123
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_a = 32'hDEAD_0123; cmd_b = 32'h0F0F_0F0F;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R12 busy after accept", 64'(cmd_ready), 0);
    check(dev_valid == 1'b1, "R8 dev_valid raised", 64'(dev_valid), 1);
    got = 1'b0;
    for (int i = 0; i < 40 && !got; i++) begin
      if (res_valid) begin
        got = 1'b1; d = res_data; trap = res_trap;
      end else begin
        if (i == 1) check(cmd_ready == 1'b0, "R12 busy while waiting", 64'(cmd_ready), 0);
        @(negedge clk);
      end
    end
    check(got, "R9 result returned", 64'(got), 1);
    check(d == dev_fn(3'd3, 12'h123, 32'hDEAD_0123, 32'h0F0F_0F0F), "R9 result data",
          64'(d), 64'(dev_fn(3'd3, 12'h123, 32'hDEAD_0123, 32'h0F0F_0F0F)));
    check(trap == 1'b0, "R9 no trap", 64'(trap), 0);
    check(seen_op == 3'd3 && seen_lun == 12'h123, "R8 op and unit",
          {32'(seen_op), 32'(seen_lun)}, {32'd3, 32'h123});
    check(seen_a == 32'hDEAD_0123 && seen_b == 32'h0F0F_0F0F, "R8 operands",
          {seen_a, seen_b}, {32'hDEAD_0123, 32'h0F0F_0F0F});
    @(negedge clk);
    check(res_valid == 1'b0, "R9 result is one cycle", 64'(res_valid), 0);
    check(cmd_ready == 1'b1, "R12 ready after result", 64'(cmd_ready), 1);

    // R8: stalled device keeps the request stable
    dev_ready = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd7; cmd_a = 32'h0000_0FFF; cmd_b = 32'h1234_5678;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_a = '0; cmd_b = '0; cmd_op = '0;
    for (int i = 0; i < 3; i++) begin
      check(dev_valid && dev_op == 3'd7 && dev_lun == 12'hFFF && dev_a == 32'h0000_0FFF
            && dev_b == 32'h1234_5678, "R8 held under stall",
            {dev_a, 20'(dev_lun), 9'(dev_op), 3'(dev_valid)},
            {32'h0000_0FFF, 20'hFFF, 9'd7, 3'd1});
      @(negedge clk);
    end
    dev_ready = 1'b1;
    got = 1'b0;
    for (int i = 0; i < 40 && !got; i++) begin
      if (res_valid) begin
        got = 1'b1; d = res_data;
      end else begin
        @(negedge clk);
      end
    end
    check(got && d == dev_fn(3'd7, 12'hFFF, 32'h0000_0FFF, 32'h1234_5678),
          "R9 result after stall", 64'(d),
          64'(dev_fn(3'd7, 12'hFFF, 32'h0000_0FFF, 32'h1234_5678)));

    // R10 R11: unit 0 with non-zero upper operand bits
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_a = 32'h5555_5000; cmd_b = 32'h1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(res_valid && res_trap && res_data == '0, "R10 trap result",
          {31'd0, res_valid, res_trap, res_data}, {31'd0, 1'b1, 1'b1, 32'd0});
    check(dev_valid == 1'b0, "R10 no device request", 64'(dev_valid), 0);
    check(res_valid_o && !res_trap_o && res_data_o == 32'hFFFF_FFFF, "R11 all-ones fallback",
          {31'd0, res_valid_o, res_trap_o, res_data_o}, {31'd0, 1'b1, 1'b0, 32'hFFFF_FFFF});
    check(res_valid_z && !res_trap_z && res_data_z == '0, "R11 all-zeros fallback",
          {31'd0, res_valid_z, res_trap_z, res_data_z}, {31'd0, 1'b1, 1'b0, 32'd0});
    @(negedge clk);
    check(dev_valid == 1'b0 && res_valid == 1'b0, "R10 nothing follows",
          {dev_valid, res_valid}, 0);

    // R10: trap command right after a normal one
    issue(3'd0, 32'h0000_0001, 32'h0, d, trap, got);
    check(got && !trap, "R9 unit 1 command", 64'(trap), 0);
    issue(3'd5, 32'h0, 32'hFFFF_FFFF, d, trap, got);
    check(got && trap && d == '0, "R10 second trap", {trap, d}, {1'b1, 32'd0});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule